// File: doc/BRIEF.md
# Primary Drive Reset Sequencer

This block runs the reset sequence for the primary drive on a disk bus that two drives share. A bus hardware reset or the host's soft-reset control bit starts it. While the sequence runs, the busy status bit is held high and the ready bit is held low. The block finds out whether a secondary drive is attached by watching the secondary's activity line inside a timed window. If a secondary drive is attached, it then waits a bounded time for that drive's pass-diagnostic line. When the sequence completes, it writes the error register and loads the fixed signature into the task-file registers.

The presence result is captured only during a hardware reset. It is kept in a register that a soft reset does not touch, so a later soft reset can decide from it whether to wait for the secondary drive. Local diagnostics run outside this block and report back through a done strobe and a 7-bit result code. Every timing window is a clock-cycle count set by a parameter.

Top module: `pdrv_reset_seq`

## Requirements
- R1: While `bus_rst_n` is low, and out of `rst`, `busy` is 1 and `ready` is 0. `busy` stays 1 from the release of the bus reset until the sequence completes.
- R2: After `bus_rst_n` rises there is a delay of `T_DELAY` cycles. Then `peer_act_n` is sampled for `T_PRES` cycles. A low level inside that window sets `peer_found`. A low level before the window opens has no effect.
- R3: A hardware-reset sequence completes only after the presence window has closed and at least one `diag_done` strobe has been taken since the bus reset was released. So `busy` stays high for at least `T_DELAY + T_PRES` cycles after the release.
- R4: When `peer_found` is 1, `peer_pass_n` is sampled for up to `T_PASS` cycles, starting when the window opens. A low level seen in time makes `err_reg[7]` 0. If none is seen, the sequence completes after the timeout with `err_reg[7]` set to 1.
- R5: When `peer_found` is 0, the sequence does not wait for `peer_pass_n` and writes `err_reg[7]` as 0.
- R6: `err_reg[6:0]` takes the `diag_code` of the most recent `diag_done` strobe accepted during the sequence.
- R7: On completion, `busy` falls and `ready` rises in the same cycle. The signature is loaded at the same time: `sec_cnt`=8'h01, `sec_num`=8'h01, `cyl_lo`=8'h00, `cyl_hi`=8'h00, `dev_head`=8'h00.
- R8: When `soft_rst` is 1 while the block is idle, `busy` goes to 1 and `ready` to 0 on the next clock. The block waits for `soft_rst` to return to 0, then waits `T_DELAY` cycles, then opens the pass-diagnostic window. The presence line is not sampled again, and `peer_found` keeps its value.
- R9: During a soft reset, a low level on `peer_pass_n` is ignored until the pass window has opened. This covers the time while `soft_rst` is held and the delay that follows.
- R10: A low level on `bus_rst_n` aborts a soft reset at any point and restarts the full hardware sequence, with presence sampled anew.
- R11: `soft_rst` is ignored while a hardware-reset sequence runs. A pulse that ends before that sequence completes starts no soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset; behaves as a bus reset being held |
| bus_rst_n | input | 1 | Bus hardware reset, active low |
| soft_rst | input | 1 | Soft-reset control bit written by the host |
| peer_act_n | input | 1 | Secondary drive presence/activity line, active low |
| peer_pass_n | input | 1 | Secondary drive pass-diagnostic line, active low |
| diag_done | input | 1 | One-cycle strobe: local diagnostics finished |
| diag_code | input | 7 | Local diagnostic result, valid with `diag_done` |
| busy | output | 1 | Busy status bit |
| ready | output | 1 | Ready status bit |
| peer_found | output | 1 | Stored result of the last presence window |
| err_reg | output | 8 | Error register: bit 7 is secondary failure, bits 6:0 are the local result |
| sec_cnt | output | 8 | Sector count signature |
| sec_num | output | 8 | Sector number signature |
| cyl_lo | output | 8 | Cylinder low signature |
| cyl_hi | output | 8 | Cylinder high signature |
| dev_head | output | 8 | Device/head signature |

## Verification
The hardest state to reach is a soft reset that has to use a presence result stored by an earlier hardware reset. A related case is a hardware reset that cuts into a soft reset halfway through. The bench first runs a hardware reset with a pulse on the activity line, so the flag is set. It then issues soft resets with the pass line driven low at different points: while the bit is still held, and inside the window. After that it pulls the bus reset in the middle of a soft hold to show that the flag is cleared and sampled again. A behavioural model with its own counters follows every cycle, so the exact cycle on which `busy` falls is checked in each of these paths.

// File: rtl/pdrv_rst_pkg.sv
package pdrv_rst_pkg;
  typedef enum logic [2:0] {
    ST_HRST  = 3'd0,
    ST_SHOLD = 3'd1,
    ST_DELAY = 3'd2,
    ST_WIN   = 3'd3,
    ST_IDLE  = 3'd4
  } seq_state_e;

  localparam logic [7:0] SIG_SEC_CNT  = 8'h01;
  localparam logic [7:0] SIG_SEC_NUM  = 8'h01;
  localparam logic [7:0] SIG_CYL_LO   = 8'h00;
  localparam logic [7:0] SIG_CYL_HI   = 8'h00;
  localparam logic [7:0] SIG_DEV_HEAD = 8'h00;
endpackage

// File: rtl/pdrv_win_timer.sv
module pdrv_win_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (run && cnt != SAT)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pdrv_peer_sampler.sv
module pdrv_peer_sampler (
  input  logic clk,
  input  logic rst,
  input  logic found_clr,
  input  logic pass_clr,
  input  logic pres_en,
  input  logic pass_en,
  input  logic peer_act_n,
  input  logic peer_pass_n,
  output logic found,
  output logic pass_seen
);
  // presence flag: only a bus reset clears it
  always_ff @(posedge clk) begin
    if (rst || found_clr)
      found <= 1'b0;
    else if (pres_en && !peer_act_n)
      found <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || pass_clr)
      pass_seen <= 1'b0;
    else if (pass_en && !peer_pass_n)
      pass_seen <= 1'b1;
  end
endmodule

// File: rtl/pdrv_status_regs.sv
module pdrv_status_regs
  import pdrv_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       diag_clr,
  input  logic       diag_en,
  input  logic       diag_done,
  input  logic [6:0] diag_code,
  input  logic       load,
  input  logic       fail_bit,
  output logic       diag_seen,
  output logic [7:0] err_reg,
  output logic [7:0] sec_cnt,
  output logic [7:0] sec_num,
  output logic [7:0] cyl_lo,
  output logic [7:0] cyl_hi,
  output logic [7:0] dev_head
);
  logic [6:0] diag_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      diag_seen <= 1'b0;
      diag_val  <= '0;
    end else if (diag_clr) begin
      diag_seen <= 1'b0;
    end else if (diag_en && diag_done) begin
      diag_seen <= 1'b1;
      diag_val  <= diag_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_reg  <= '0;
      sec_cnt  <= '0;
      sec_num  <= '0;
      cyl_lo   <= '0;
      cyl_hi   <= '0;
      dev_head <= '0;
    end else if (load) begin
      err_reg  <= {fail_bit, diag_val};
      sec_cnt  <= SIG_SEC_CNT;
      sec_num  <= SIG_SEC_NUM;
      cyl_lo   <= SIG_CYL_LO;
      cyl_hi   <= SIG_CYL_HI;
      dev_head <= SIG_DEV_HEAD;
    end
  end
endmodule

// File: rtl/pdrv_reset_seq.sv
module pdrv_reset_seq
  import pdrv_rst_pkg::*;
#(
  parameter int T_DELAY = 4,
  parameter int T_PRES  = 10,
  parameter int T_PASS  = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_rst_n,
  input  logic       soft_rst,
  input  logic       peer_act_n,
  input  logic       peer_pass_n,
  input  logic       diag_done,
  input  logic [6:0] diag_code,
  output logic       busy,
  output logic       ready,
  output logic       peer_found,
  output logic [7:0] err_reg,
  output logic [7:0] sec_cnt,
  output logic [7:0] sec_num,
  output logic [7:0] cyl_lo,
  output logic [7:0] cyl_hi,
  output logic [7:0] dev_head
);
  localparam int CNT_MAX = (T_PASS > T_DELAY) ? T_PASS : T_DELAY;
  localparam int CW      = $clog2(CNT_MAX + 2);
  localparam logic [CW-1:0] DLY_LAST = CW'(T_DELAY - 1);
  localparam logic [CW-1:0] PRES_END = CW'(T_PRES);
  localparam logic [CW-1:0] PASS_END = CW'(T_PASS);

  seq_state_e state, state_nx;
  logic is_hw, is_hw_nx, busy_nx, ready_nx;
  logic cnt_clr, cnt_run, found_clr, seq_clr, diag_en, done;
  logic pass_seen, diag_seen, done_cond;
  logic [CW-1:0] cnt;

  pdrv_win_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clear(cnt_clr), .run(cnt_run), .cnt(cnt)
  );

  pdrv_peer_sampler u_sampler (
    .clk(clk), .rst(rst), .found_clr(found_clr), .pass_clr(seq_clr),
    .pres_en(state == ST_WIN && is_hw && cnt < PRES_END),
    .pass_en(state == ST_WIN && !seq_clr),
    .peer_act_n(peer_act_n), .peer_pass_n(peer_pass_n),
    .found(peer_found), .pass_seen(pass_seen)
  );

  pdrv_status_regs u_status (
    .clk(clk), .rst(rst), .diag_clr(seq_clr), .diag_en(diag_en),
    .diag_done(diag_done), .diag_code(diag_code), .load(done),
    .fail_bit(peer_found && !pass_seen), .diag_seen(diag_seen),
    .err_reg(err_reg), .sec_cnt(sec_cnt), .sec_num(sec_num),
    .cyl_lo(cyl_lo), .cyl_hi(cyl_hi), .dev_head(dev_head)
  );

  assign done_cond = diag_seen
                  && (!is_hw || cnt >= PRES_END)
                  && (!peer_found || pass_seen || cnt >= PASS_END);

  always_comb begin
    state_nx  = state;
    is_hw_nx  = is_hw;
    busy_nx   = busy;
    ready_nx  = ready;
    cnt_clr   = 1'b0;
    cnt_run   = 1'b0;
    found_clr = 1'b0;
    seq_clr   = 1'b0;
    diag_en   = 1'b0;
    done      = 1'b0;
    if (!bus_rst_n) begin
      state_nx  = ST_HRST;
      is_hw_nx  = 1'b1;
      busy_nx   = 1'b1;
      ready_nx  = 1'b0;
      cnt_clr   = 1'b1;
      found_clr = 1'b1;
      seq_clr   = 1'b1;
    end else begin
      case (state)
        ST_HRST: begin
          state_nx = ST_DELAY;
          is_hw_nx = 1'b1;
          cnt_clr  = 1'b1;
          diag_en  = 1'b1;
        end
        ST_IDLE: begin
          if (soft_rst) begin
            state_nx = ST_SHOLD;
            is_hw_nx = 1'b0;
            busy_nx  = 1'b1;
            ready_nx = 1'b0;
            seq_clr  = 1'b1;
            cnt_clr  = 1'b1;
          end
        end
        ST_SHOLD: begin
          diag_en = 1'b1;
          if (!soft_rst) begin
            state_nx = ST_DELAY;
            cnt_clr  = 1'b1;
          end
        end
        ST_DELAY, ST_WIN: begin
          if (!is_hw && soft_rst) begin
            state_nx = ST_SHOLD;
            seq_clr  = 1'b1;
            cnt_clr  = 1'b1;
          end else if (state == ST_DELAY) begin
            diag_en = 1'b1;
            cnt_run = 1'b1;
            if (cnt == DLY_LAST) begin
              state_nx = ST_WIN;
              cnt_clr  = 1'b1;
            end
          end else begin
            diag_en = 1'b1;
            cnt_run = 1'b1;
            if (done_cond) begin
              state_nx = ST_IDLE;
              busy_nx  = 1'b0;
              ready_nx = 1'b1;
              done     = 1'b1;
            end
          end
        end
        default: state_nx = ST_HRST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HRST;
      is_hw <= 1'b1;
      busy  <= 1'b1;
      ready <= 1'b0;
    end else begin
      state <= state_nx;
      is_hw <= is_hw_nx;
      busy  <= busy_nx;
      ready <= ready_nx;
    end
  end
endmodule

// File: rtl/pdrv_reset_seq_chk.sv
module pdrv_reset_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_rst_n,
  input logic       busy,
  input logic       ready,
  input logic       peer_found,
  input logic [7:0] err_reg,
  input logic [7:0] sec_cnt,
  input logic [7:0] sec_num,
  input logic [7:0] cyl_lo,
  input logic [7:0] cyl_hi,
  input logic [7:0] dev_head
);
  // R1: a bus reset forces busy and drops ready on the next edge
  a_r1_busy_in_reset: assert property (@(posedge clk) disable iff (rst)
    !bus_rst_n |=> (busy && !ready));

  // R7: the two status bits never show at the same time
  a_r7_status_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && ready));

  // R7: signature is present whenever busy drops
  a_r7_signature: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (sec_cnt == 8'h01 && sec_num == 8'h01 && cyl_lo == 8'h00
                     && cyl_hi == 8'h00 && dev_head == 8'h00 && ready));

  // R5: with no secondary drive, the failure bit is clear on completion
  a_r5_no_peer_clear: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !peer_found) |-> !err_reg[7]);

  // R2: the presence flag can only be set while a sequence is running
  a_r2_found_while_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(peer_found) |-> busy);
endmodule

bind pdrv_reset_seq pdrv_reset_seq_chk u_chk (
  .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .busy(busy), .ready(ready),
  .peer_found(peer_found), .err_reg(err_reg), .sec_cnt(sec_cnt),
  .sec_num(sec_num), .cyl_lo(cyl_lo), .cyl_hi(cyl_hi), .dev_head(dev_head)
);

// File: tb/tb_pdrv_reset_seq.sv
module tb_pdrv_reset_seq;
  localparam int T_DELAY = 4;
  localparam int T_PRES  = 10;
  localparam int T_PASS  = 30;

  logic clk = 0, rst = 1, bus_rst_n = 0, soft_rst = 0;
  logic peer_act_n = 1, peer_pass_n = 1, diag_done = 0;
  logic [6:0] diag_code = '0;
  logic busy, ready, peer_found;
  logic [7:0] err_reg, sec_cnt, sec_num, cyl_lo, cyl_hi, dev_head;

  int checks = 0, fails = 0, cyc_cnt = 0;

  pdrv_reset_seq #(.T_DELAY(T_DELAY), .T_PRES(T_PRES), .T_PASS(T_PASS)) dut (
    .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .soft_rst(soft_rst),
    .peer_act_n(peer_act_n), .peer_pass_n(peer_pass_n), .diag_done(diag_done),
    .diag_code(diag_code), .busy(busy), .ready(ready), .peer_found(peer_found),
    .err_reg(err_reg), .sec_cnt(sec_cnt), .sec_num(sec_num), .cyl_lo(cyl_lo),
    .cyl_hi(cyl_hi), .dev_head(dev_head)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: phases 0 hw-reset, 1 soft hold, 2 delay, 3 window, 4 idle
  int mph, mt, mfound, mpass, mdiag, mcode, mhw, mbusy, mready, merr, msig;
  bit model_on = 0;

  always @(posedge clk) begin
    cyc_cnt++;
    if (rst) begin
      mph = 0; mhw = 1; mbusy = 1; mready = 0; mfound = 0; mpass = 0;
      mdiag = 0; mcode = 0; merr = 0; msig = 0; mt = 0; model_on = 1;
    end else if (!bus_rst_n) begin
      mph = 0; mhw = 1; mbusy = 1; mready = 0; mt = 0;
      mfound = 0; mpass = 0; mdiag = 0;
    end else begin
      case (mph)
        0: begin
          mph = 2; mt = 0; mhw = 1;
          if (diag_done) begin mdiag = 1; mcode = diag_code; end
        end
        4: if (soft_rst) begin
          mph = 1; mhw = 0; mbusy = 1; mready = 0; mpass = 0; mdiag = 0; mt = 0;
        end
        1: begin
          if (diag_done) begin mdiag = 1; mcode = diag_code; end
          if (!soft_rst) begin mph = 2; mt = 0; end
        end
        default: begin
          if (!mhw && soft_rst) begin
            mph = 1; mpass = 0; mdiag = 0; mt = 0;
          end else if (mph == 2) begin
            if (diag_done) begin mdiag = 1; mcode = diag_code; end
            if (mt == T_DELAY - 1) begin mph = 3; mt = 0; end else mt++;
          end else begin
            if (mdiag && (!mhw || mt >= T_PRES) && (!mfound || mpass || mt >= T_PASS)) begin
              merr = ((mfound && !mpass) ? 128 : 0) + mcode;
              msig = 1; mbusy = 0; mready = 1; mph = 4;
            end
            if (mhw && mt < T_PRES && !peer_act_n) mfound = 1;
            if (!peer_pass_n) mpass = 1;
            if (diag_done) begin mdiag = 1; mcode = diag_code; end
            mt++;
          end
        end
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc_cnt);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk("R1 busy vs model", int'(busy), mbusy);
      chk("R7 ready vs model", int'(ready), mready);
      chk("R2 peer_found vs model", int'(peer_found), mfound);
      chk("R4 err_reg vs model", int'(err_reg), merr);
      chk("R7 sec_cnt vs model", int'(sec_cnt), msig);
      chk("R7 sec_num vs model", int'(sec_num), msig);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_diag(input logic [6:0] code);
    @(negedge clk); diag_done = 1; diag_code = code;
    @(negedge clk); diag_done = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic check_sig(input string req);
    chk(req, int'({sec_cnt, sec_num, cyl_lo, cyl_hi, dev_head}), 40'h0101000000);
  endtask

  task automatic hw_reset();
    @(negedge clk); bus_rst_n = 0;
    cyc(3);
    bus_rst_n = 1;
  endtask

  initial begin : watchdog
    #(5ns * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int t0;
    cyc(3);
    chk("R1 busy in reset", int'(busy), 1);
    chk("R1 ready in reset", int'(ready), 0);
    rst = 0;
    cyc(2);
    chk("R1 busy while bus reset low", int'(busy), 1);

    // no secondary drive
    bus_rst_n = 1; t0 = cyc_cnt;
    cyc(1);
    pulse_diag(7'h15);
    wait_idle();
    chk("R3 busy time lower bound", int'((cyc_cnt - t0) >= T_DELAY + T_PRES), 1);
    chk("R5 no peer err", int'(err_reg), 8'h15);
    chk("R6 code", int'(err_reg[6:0]), 7'h15);
    chk("R7 ready at completion", int'(ready), 1);
    check_sig("R7 signature");

    // activity low only during delay: ignored
    hw_reset();
    peer_act_n = 0; cyc(2); peer_act_n = 1;
    pulse_diag(7'h01);
    wait_idle();
    chk("R2 early presence ignored", int'(peer_found), 0);

    // secondary present, passes
    hw_reset();
    cyc(T_DELAY + 3);
    peer_act_n = 0; cyc(2); peer_act_n = 1;
    pulse_diag(7'h02);
    cyc(T_PRES);
    peer_pass_n = 0;
    wait_idle();
    peer_pass_n = 1;
    chk("R2 presence found", int'(peer_found), 1);
    chk("R4 pass in time", int'(err_reg), 8'h02);

    // secondary present, times out; soft pulse during hw is ignored
    hw_reset(); t0 = cyc_cnt;
    cyc(T_DELAY + 2);
    peer_act_n = 0; cyc(1); peer_act_n = 1;
    soft_rst = 1; cyc(2); soft_rst = 0;
    pulse_diag(7'h33);
    wait_idle();
    chk("R4 timeout length", int'((cyc_cnt - t0) >= T_DELAY + T_PASS), 1);
    chk("R4 timeout err", int'(err_reg), 8'hB3);
    cyc(3);
    chk("R11 soft pulse ignored", int'(busy), 0);

    // soft reset, pass held low during hold only: ignored, times out
    @(negedge clk); soft_rst = 1;
    @(negedge clk);
    chk("R8 busy on soft", int'(busy), 1);
    peer_pass_n = 0;
    pulse_diag(7'h44);
    cyc(3);
    peer_pass_n = 1; soft_rst = 0;
    wait_idle();
    chk("R9 early pass ignored", int'(err_reg), 8'hC4);
    chk("R8 found kept", int'(peer_found), 1);

    // soft reset with pass inside window
    @(negedge clk); soft_rst = 1;
    cyc(2); soft_rst = 0;
    pulse_diag(7'h05);
    cyc(T_DELAY + 2);
    peer_pass_n = 0;
    wait_idle();
    peer_pass_n = 1;
    chk("R8 soft pass err", int'(err_reg), 8'h05);
    check_sig("R7 signature after soft");

    // hardware reset overrides soft hold, no peer now
    @(negedge clk); soft_rst = 1;
    cyc(3);
    bus_rst_n = 0; soft_rst = 0;
    @(negedge clk);
    chk("R10 busy on override", int'(busy), 1);
    cyc(2); bus_rst_n = 1;
    pulse_diag(7'h06);
    wait_idle();
    chk("R10 presence resampled", int'(peer_found), 0);
    chk("R10 err after override", int'(err_reg), 8'h06);

    // soft reset without peer: no pass wait
    @(negedge clk); soft_rst = 1;
    cyc(2); soft_rst = 0;
    pulse_diag(7'h07);
    wait_idle();
    chk("R5 soft no peer", int'(err_reg), 8'h07);
    chk("R8 ready after soft", int'(ready), 1);

    cyc(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule